// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block turns a handful of supply and health indications into a system reset and a watchdog timeout. It runs from a free-running clock and counts time in units of a one-cycle tick strobe, nominally one millisecond. Reset is driven while power is not yet good, while the primary low-voltage comparator flag is set or while the debounced manual reset pin is held. Once all of these have cleared, reset is held for a power-on delay chosen by a 2-bit field and then released. Upstream logic holds the delay field at 01 and the watchdog field at 11 until software configures them.

An independent watchdog counts ticks and emits a one-clock timeout pulse if it is not restarted within the period chosen by a second 2-bit field. One encoding of that field turns the watchdog off. A fault byte records which condition caused trouble. Each cause has a sticky bit that is set when the cause rises. A host can overwrite the byte with one write strobe, and no unlock sequence is needed. All inputs are taken to be synchronous to the clock. Every time constant is a parameter, so a simulation can use short counts.

Top module: `supv_reset_ctrl`

## Requirements
- R1: After reset release or a rise of `pwr_ok_i`, `rst_o` stays high and falls at the clock edge of the Nth tick counted from the first edge at which no hold cause is present. N is selected by `por_sel_i`: 00 gives POR_T0 (50), 01 gives POR_T1 (200), 10 gives POR_T2 (400) and 11 gives POR_T3 (800).
- R2: While `pwr_ok_i` is low or `lv_i[0]` is high, `rst_o` is high from the next clock on. After both clear, the R1 delay is applied again from the start.
- R3: Manual reset is recognised only after `mr_ni` has been low for MR_TICKS consecutive ticks. Reset is then held until the pin goes high, after which the R1 delay applies. A shorter low period changes neither `rst_o` nor the manual fault bit.
- R4: With `wd_sel_i` set to 00 (WDT_T0, 1400 ticks), 01 (WDT_T1, 200 ticks) or 10 (WDT_T2, 25 ticks) and no restart, `wdt_o` pulses high for exactly one clock every period. Consecutive pulses are the selected number of ticks apart.
- R5: With `wd_sel_i` = 11 the watchdog is stopped and `wdt_o` stays low.
- R6: A rising edge on `kick_i`, or `rst_o` being high, restarts the watchdog count. No timeout occurs while restarts come more often than the period, and none occurs while reset is held.
- R7: Fault byte `flt_o` has bit 7 for the primary low voltage (`lv_i[0]`), bit 6 for the second (`lv_i[1]`), bit 5 for the third (`lv_i[2]`), bit 4 for the watchdog timeout and bit 3 for manual reset. Bits 2..0 always read 0, and the byte is 0 after `rst_ni`. Each bit is set on the clock after its cause rises.
- R8: Fault bits stay set until `flt_we_i` loads bits 7..3 of `flt_wdata_i`. A cause rising in the same cycle as a write wins over the write.
- R9: `lv_i[1]` and `lv_i[2]` only record faults. They never assert `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base strobe |
| pwr_ok_i | input | 1 | Power good level |
| lv_i | input | 3 | Low-voltage flags, bit 0 primary |
| mr_ni | input | 1 | Manual reset pin, active low |
| kick_i | input | 1 | Watchdog restart, rising edge |
| por_sel_i | input | 2 | Power-on delay select |
| wd_sel_i | input | 2 | Watchdog period select, 11 = off |
| flt_we_i | input | 1 | Fault byte write strobe |
| flt_wdata_i | input | 8 | Fault byte write data |
| rst_o | output | 1 | System reset, active high |
| wdt_o | output | 1 | Watchdog timeout pulse |
| flt_o | output | 8 | Sticky fault byte |

## Verification
The release delay is measured for all four delay codes, both after a power-good rise and after a primary low-voltage episode. This separates a wrong decode from a wrong restart of the count. The manual pin is held low once for fewer ticks than the debounce length and once for more, which tells a missing debounce from an off-by-one count. The watchdog is run free at every enabled period, switched off, kicked faster than its period and held in reset; this separates period decoding, disabling and the two restart paths. Host writes are made both alone and in the same cycle as a new fault, which checks overwrite against set priority.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int unsigned N_SRC    = 5;
  localparam int unsigned FLT_W    = 8;
  localparam int unsigned FLT_LSB  = FLT_W - N_SRC;
  localparam logic [1:0]  WD_OFF   = 2'b11;
endpackage

// File: rtl/supv_por_seq.sv
module supv_por_seq #(
  parameter int unsigned D0 = 50,
  parameter int unsigned D1 = 200,
  parameter int unsigned D2 = 400,
  parameter int unsigned D3 = 800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic [1:0] sel_i,
  output logic       rst_o
);
  localparam int unsigned M01  = (D0 > D1) ? D0 : D1;
  localparam int unsigned M23  = (D2 > D3) ? D2 : D3;
  localparam int unsigned DMAX = (M01 > M23) ? M01 : M23;
  localparam int unsigned CW   = $clog2(DMAX + 1);

  logic [CW-1:0] last, cnt_q;
  logic          rst_q;

  always_comb begin
    unique case (sel_i)
      2'b00:   last = CW'(D0 - 1);
      2'b01:   last = CW'(D1 - 1);
      2'b10:   last = CW'(D2 - 1);
      default: last = CW'(D3 - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (hold_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q && tick_i) begin
      if (cnt_q >= last) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/supv_mr_deb.sv
module supv_mr_deb #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mr_ni,
  output logic act_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (mr_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick_i && !act_q) begin
      if (cnt_q >= CW'(TICKS - 1)) act_q <= 1'b1;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/supv_wdt.sv
module supv_wdt #(
  parameter int unsigned W0 = 1400,
  parameter int unsigned W1 = 200,
  parameter int unsigned W2 = 25
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       sys_rst_i,
  input  logic [1:0] sel_i,
  output logic       tmo_o
);
  import supv_pkg::*;
  localparam int unsigned M01  = (W0 > W1) ? W0 : W1;
  localparam int unsigned WMAX = (M01 > W2) ? M01 : W2;
  localparam int unsigned CW   = $clog2(WMAX + 1);

  logic [CW-1:0] last, cnt_q;
  logic          kick_q, tmo_q, restart, expire;

  always_comb begin
    unique case (sel_i)
      2'b00:   last = CW'(W0 - 1);
      2'b01:   last = CW'(W1 - 1);
      2'b10:   last = CW'(W2 - 1);
      default: last = '0;
    endcase
  end

  assign restart = sys_rst_i | (kick_i & ~kick_q) | (sel_i == WD_OFF);
  assign expire  = tick_i & (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kick_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      kick_q <= kick_i;
      tmo_q  <= ~restart & expire;
      if (restart)     cnt_q <= '0;
      else if (expire) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tmo_o = tmo_q;
endmodule

// File: rtl/supv_fault_log.sv
module supv_fault_log #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic src_q, flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q  <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        src_q  <= src_i[i];
        // a new cause wins over a host write in the same cycle
        flag_q <= (we_i ? wdata_i[i] : flag_q) | (src_i[i] & ~src_q);
      end
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int unsigned POR_T0   = 50,
  parameter int unsigned POR_T1   = 200,
  parameter int unsigned POR_T2   = 400,
  parameter int unsigned POR_T3   = 800,
  parameter int unsigned WDT_T0   = 1400,
  parameter int unsigned WDT_T1   = 200,
  parameter int unsigned WDT_T2   = 25,
  parameter int unsigned MR_TICKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pwr_ok_i,
  input  logic [2:0] lv_i,
  input  logic       mr_ni,
  input  logic       kick_i,
  input  logic [1:0] por_sel_i,
  input  logic [1:0] wd_sel_i,
  input  logic       flt_we_i,
  input  logic [7:0] flt_wdata_i,
  output logic       rst_o,
  output logic       wdt_o,
  output logic [7:0] flt_o
);
  logic             mr_act, hold, sys_rst, tmo;
  logic [N_SRC-1:0] src, flags;
  logic             unused_wlsb;

  supv_mr_deb #(.TICKS(MR_TICKS)) u_mr (
    .clk_i, .rst_ni, .tick_i, .mr_ni, .act_o(mr_act)
  );

  assign hold = ~pwr_ok_i | lv_i[0] | mr_act;

  supv_por_seq #(.D0(POR_T0), .D1(POR_T1), .D2(POR_T2), .D3(POR_T3)) u_por (
    .clk_i, .rst_ni, .tick_i, .hold_i(hold), .sel_i(por_sel_i), .rst_o(sys_rst)
  );

  supv_wdt #(.W0(WDT_T0), .W1(WDT_T1), .W2(WDT_T2)) u_wdt (
    .clk_i, .rst_ni, .tick_i, .kick_i, .sys_rst_i(sys_rst), .sel_i(wd_sel_i), .tmo_o(tmo)
  );

  // order matches fault byte bits 7..3
  assign src = {lv_i[0], lv_i[1], lv_i[2], tmo, mr_act};

  supv_fault_log #(.N(N_SRC)) u_flt (
    .clk_i, .rst_ni, .src_i(src), .we_i(flt_we_i),
    .wdata_i(flt_wdata_i[FLT_W-1:FLT_LSB]), .flags_o(flags)
  );

  assign unused_wlsb = ^flt_wdata_i[FLT_LSB-1:0];
  assign rst_o = sys_rst;
  assign wdt_o = tmo;
  assign flt_o = {flags, {FLT_LSB{1'b0}}};
endmodule

// File: rtl/supv_reset_ctrl_chk.sv
module supv_reset_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       pwr_ok_i,
  input logic [2:0] lv_i,
  input logic       mr_ni,
  input logic       kick_i,
  input logic [1:0] por_sel_i,
  input logic [1:0] wd_sel_i,
  input logic       flt_we_i,
  input logic [7:0] flt_wdata_i,
  input logic       rst_o,
  input logic       wdt_o,
  input logic [7:0] flt_o
);
  p_release_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> $past(tick_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv_i[0] || !pwr_ok_i) |=> rst_o);

  p_wdt_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_o |-> ($past(wd_sel_i) != 2'b11));

  p_wdt_quiet_in_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_o |-> !$past(rst_o));

  p_wdt_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_o |=> flt_o[4]);

  p_lv_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lv_i[0]) |=> flt_o[7]);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_we_i |=> ((flt_o[7:3] & $past(flt_o[7:3])) == $past(flt_o[7:3])));
endmodule

bind supv_reset_ctrl supv_reset_ctrl_chk chk_i (.*);

// File: tb/supv_reset_ctrl_tb_top.sv
module supv_reset_ctrl_tb_top;
  localparam int P0 = 3, P1 = 5, P2 = 7, P3 = 9;
  localparam int W0 = 20, W1 = 11, W2 = 6;
  localparam int DEB = 3;

  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic       pwr_ok_i = 1'b0, mr_ni = 1'b1, kick_i = 1'b0, flt_we_i = 1'b0;
  logic [2:0] lv_i = '0;
  logic [1:0] por_sel_i = 2'b01, wd_sel_i = 2'b11;
  logic [7:0] flt_wdata_i = '0;
  logic       rst_o, wdt_o;
  logic [7:0] flt_o;

  int checks = 0, fails = 0, cyc = 0, tick_seen = 0;
  int plim[4] = '{P0, P1, P2, P3};
  int wlim[3] = '{W0, W1, W2};

  supv_reset_ctrl #(.POR_T0(P0), .POR_T1(P1), .POR_T2(P2), .POR_T3(P3),
                    .WDT_T0(W0), .WDT_T1(W1), .WDT_T2(W2), .MR_TICKS(DEB)) dut_i (.*);

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    cyc++;
    tick_i = (cyc % 4 == 0);
  end

  always @(posedge clk_i) if (rst_ni && tick_i) tick_seen++;

  // behavioural reference
  bit m_rst, m_mract, m_wdt, m_kq;
  int m_dcnt, m_mcnt, m_wcnt;
  bit [4:0] m_flt, m_srcq;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rst = 1; m_mract = 0; m_wdt = 0; m_kq = 0;
      m_dcnt = 0; m_mcnt = 0; m_wcnt = 0; m_flt = 0; m_srcq = 0;
    end else begin
      bit hold, restart, n_rst, n_mract, n_wdt;
      int n_dcnt, n_mcnt, n_wcnt;
      bit [4:0] src, n_flt;
      hold = !pwr_ok_i || lv_i[0] || m_mract;
      n_rst = m_rst; n_dcnt = m_dcnt;
      if (hold) begin n_rst = 1; n_dcnt = 0; end
      else if (m_rst && tick_i) begin
        if (m_dcnt >= plim[por_sel_i] - 1) begin n_rst = 0; n_dcnt = 0; end
        else n_dcnt = m_dcnt + 1;
      end
      n_mract = m_mract; n_mcnt = m_mcnt;
      if (mr_ni) begin n_mract = 0; n_mcnt = 0; end
      else if (tick_i && !m_mract) begin
        if (m_mcnt >= DEB - 1) n_mract = 1; else n_mcnt = m_mcnt + 1;
      end
      restart = m_rst || (kick_i && !m_kq) || (wd_sel_i == 2'b11);
      n_wdt = 0; n_wcnt = m_wcnt;
      if (restart) n_wcnt = 0;
      else if (tick_i) begin
        if (m_wcnt >= wlim[wd_sel_i] - 1) begin n_wdt = 1; n_wcnt = 0; end
        else n_wcnt = m_wcnt + 1;
      end
      src = {lv_i[0], lv_i[1], lv_i[2], m_wdt, m_mract};
      n_flt = (flt_we_i ? flt_wdata_i[7:3] : m_flt) | (src & ~m_srcq);
      m_srcq = src; m_flt = n_flt; m_kq = kick_i;
      m_rst = n_rst; m_dcnt = n_dcnt; m_mract = n_mract; m_mcnt = n_mcnt;
      m_wdt = n_wdt; m_wcnt = n_wcnt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    chk("R2 rst_o vs model", rst_o, m_rst);
    chk("R4 wdt_o vs model", wdt_o, m_wdt);
    chk("R7 flt_o vs model", flt_o, {m_flt, 3'b000});
  end

  task automatic nclk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_rel(output int ticks);
    int t0 = tick_seen;
    for (int i = 0; i < 400 && rst_o; i++) @(negedge clk_i);
    ticks = tick_seen - t0;
  endtask

  task automatic wait_wdt(output bit seen);
    seen = 0;
    for (int i = 0; i < 600 && !seen; i++) begin
      @(negedge clk_i);
      seen = wdt_o;
    end
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk_i); flt_we_i = 1; flt_wdata_i = d;
    @(negedge clk_i); flt_we_i = 0;
  endtask

  int pulses;
  always @(negedge clk_i) if (wdt_o) pulses++;

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t;
    bit seen;
    nclk(3);
    rst_ni = 1;
    nclk(1);
    chk("R7 reset state flt_o", flt_o, 0);
    chk("R1 reset state rst_o", rst_o, 1);
    chk("R4 reset state wdt_o", wdt_o, 0);

    // R1: each delay code after power good rises
    for (int s = 0; s < 4; s++) begin
      @(negedge clk_i); pwr_ok_i = 0; por_sel_i = 2'(s);
      nclk(3);
      chk("R2 held while power not good", rst_o, 1);
      pwr_ok_i = 1;
      wait_rel(t);
      chk("R1 release delay in ticks", t, plim[s]);
    end

    // R2: primary low voltage
    @(negedge clk_i); por_sel_i = 2'b10; lv_i[0] = 1;
    nclk(12);
    chk("R2 held during primary low voltage", rst_o, 1);
    chk("R7 primary fault bit7", flt_o[7], 1);
    lv_i[0] = 0;
    wait_rel(t);
    chk("R2 delay after low voltage", t, P2);

    // R9: secondary flags only log
    @(negedge clk_i); lv_i[1] = 1;
    nclk(6); lv_i[2] = 1;
    nclk(10);
    chk("R9 secondary flags keep rst_o low", rst_o, 0);
    chk("R7 fault bits 6 and 5", flt_o[6:5], 2'b11);
    lv_i = 0;

    // R8: overwrite, sticky, set wins
    host_wr(8'h00);
    chk("R8 host clear", flt_o, 0);
    nclk(20);
    chk("R8 stays clear without cause", flt_o, 0);
    @(negedge clk_i); flt_we_i = 1; flt_wdata_i = 8'h00; lv_i[1] = 1;
    @(negedge clk_i); flt_we_i = 0;
    chk("R8 rising cause wins over write", flt_o, 8'h40);
    lv_i[1] = 0;
    host_wr(8'hFF);
    chk("R7 low bits read zero after write", flt_o, 8'hF8);
    host_wr(8'h00);

    // R3: short glitch then real press
    @(negedge clk_i); mr_ni = 0;
    nclk(6); mr_ni = 1;
    nclk(10);
    chk("R3 short low ignored rst_o", rst_o, 0);
    chk("R3 short low no fault bit3", flt_o[3], 0);
    mr_ni = 0;
    nclk(40);
    chk("R3 long low asserts rst_o", rst_o, 1);
    chk("R3 fault bit3 set", flt_o[3], 1);
    mr_ni = 1;
    wait_rel(t);
    chk("R3 delay after manual release", t, P2);
    host_wr(8'h00);

    // R4: periods
    for (int s = 0; s < 3; s++) begin
      @(negedge clk_i); wd_sel_i = 2'(s);
      wait_wdt(seen);
      t = tick_seen;
      nclk(1);
      chk("R4 pulse lasts one clock", wdt_o, 0);
      wait_wdt(seen);
      chk("R4 period in ticks", tick_seen - t, wlim[s]);
      chk("R7 watchdog fault bit4", flt_o[4], 1);
    end

    // R5: disabled
    @(negedge clk_i); wd_sel_i = 2'b11; pulses = 0;
    nclk(300);
    chk("R5 no pulse when disabled", pulses, 0);

    // R6: kicks and reset restart
    @(negedge clk_i); wd_sel_i = 2'b10; pulses = 0;
    for (int k = 0; k < 25; k++) begin
      nclk(10); kick_i = 1;
      nclk(2); kick_i = 0;
    end
    chk("R6 kicks prevent timeout", pulses, 0);
    wait_wdt(seen);
    chk("R6 timeout once kicks stop", seen, 1);
    @(negedge clk_i); lv_i[0] = 1; pulses = 0;
    nclk(200);
    chk("R6 no timeout while reset held", pulses, 0);
    lv_i[0] = 0;
    wait_rel(t);
    wait_wdt(seen);
    chk("R6 watchdog runs after release", seen, 1);

    nclk(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule